// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block watches a bank of wired interrupt lines and turns each assertion into a posted write message. The message is aimed at one doorbell address fixed at build time. Its data word carries a device identifier and an event identifier that belong to the pin. The pins are split into nodes of 128. Each node owns a 4 KiB register window, and window 0 carries no pin registers. In that window software selects each pin's trigger style, either level-high or rising-edge, and programs each pin's event identifier.

A pin that fires becomes pending and produces exactly one message. It stays silent until software writes a 1 to its bit in the chip-wide clear bank. This is normally done at end of interrupt. The block offers one message at a time on a valid/ready output. When several pins wait at once, they take turns in rotating order across the whole chip. Every input line is synchronized by two flops before its trigger is evaluated.

Top module: `wire2msg_gen`

## Requirements
- R1: Chip pin c (0 based) belongs to node n = c/128 + 1 with local pin p = c%128. Its trigger bit is bit p%32 of the word at n*0x1000 + 4*(p/32). Its vector register is at n*0x1000 + 0x200 + 4*p. Its clear bit is bit c%32 of the word at 0xA000 + 4*(c/32).
- R2: In a vector register, bits [21:12] hold the event identifier, which is writable and resets to 0. Bits [11:0] read the device identifier 0x100 + n, which is read-only, so writes leave it unchanged. All other bits read 0.
- R3: A trigger bit of 1 selects level-high and 0 selects rising-edge. All trigger bits reset to 0 and read back as written.
- R4: An edge-mode pin sends one message per rising edge. A line still held high after its clear sends nothing until it falls and rises again.
- R5: A level-mode pin whose line is still high after its clear sends a new message. If the line is low at the clear, it sends nothing.
- R6: Once a pin has fired, no further message comes from it until its clear bit is written. New edges in that time are ignored.
- R7: Writing 1 to a clear bit ends that pin's pending state. Bits written as 0 have no effect. Clear words read as 0.
- R8: Every message has msg_addr = 0x0800_0040 and msg_data = {10'b0, event[9:0], device[11:0]}. A message stays valid and unchanged until msg_ready is seen high.
- R9: Pins that wait at the same time are served in ascending chip index, cyclically, starting after the last pin served. After reset the search starts at pin 0.
- R10: Read data and reg_rvalid appear exactly one cycle after a read request. Reads of unmapped word addresses return 0. Writes to unmapped addresses change nothing.
- R11: After reset, msg_valid and reg_rvalid are low.
- R12: With the output idle and no other pin waiting, msg_valid rises on the fourth rising clock edge after a pin line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NODES*PPN | Wired interrupt lines, index = chip pin |
| reg_req | input | 1 | Register access request, one per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after request |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken when high with msg_valid |
| msg_addr | output | 32 | Doorbell address of the message |
| msg_data | output | 32 | Device and event identifiers |

## Verification
The assertions assume that the bench changes msg_ready, reg_req and the pin lines only between clock edges. They also assume that a request is treated as accepted in the cycle it is presented. The bench drives every input on the falling edge and issues register accesses one at a time. It raises each random batch of pins in a single cycle while msg_ready is held low, so every pin in the batch is waiting before the first grant and the rotating order can be predicted. All pins in the random batches are kept in edge mode, and each batch is cleared and its lines lowered before the next one starts.

// File: rtl/w2m_pkg.sv
package w2m_pkg;

  localparam int EVT_W   = 10;
  localparam int DEV_W   = 12;
  localparam int WIN_SZ  = 4096;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_TYPE,
    RK_VEC,
    RK_CLR
  } reg_kind_t;

  // device identifier of a node (node numbers start at 1)
  function automatic logic [DEV_W-1:0] dev_id(input int node, input int base);
    return DEV_W'(base + node);
  endfunction

  // node number owning a chip pin
  function automatic int node_of(input int chip_pin, input int ppn);
    return chip_pin / ppn + 1;
  endfunction

  // message / vector data word
  function automatic logic [31:0] msg_word(input logic [DEV_W-1:0] dev,
                                           input logic [EVT_W-1:0] evt);
    return {{(32 - EVT_W - DEV_W){1'b0}}, evt, dev};
  endfunction

endpackage

// File: rtl/w2m_sync.sv
module w2m_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/w2m_regs.sv
module w2m_regs
  import w2m_pkg::*;
#(
  parameter int NODES    = 2,
  parameter int PPN      = 128,
  parameter int ADDR_W   = 16,
  parameter int DEV_BASE = 256,
  parameter int VEC_BASE = 512,
  parameter int CLR_BASE = 40960
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_req,
  input  logic                                reg_wr,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  output logic                                reg_rvalid,
  output logic [NODES*PPN-1:0]                trig_lvl,
  output logic [NODES*PPN-1:0][EVT_W-1:0]     evt_ids,
  output logic [NODES*PPN-1:0]                clr_hit
);
  localparam int TOTAL     = NODES * PPN;
  localparam int IDX_W     = $clog2(TOTAL);
  localparam int TW        = PPN / 32;
  localparam int CLR_WORDS = TOTAL / 32;
  localparam int WSEL_W    = IDX_W - 5;

  reg_kind_t          kind;
  logic [WSEL_W-1:0]  word_sel;
  logic [IDX_W-1:0]   pin_sel;
  int                 node_i;
  int                 off_i;
  int                 addr_i;
  logic [31:0]        rd_next;

  logic [TOTAL-1:0]            trig_q;
  logic [TOTAL-1:0][EVT_W-1:0] evt_q;

  // address decode
  always_comb begin
    kind     = RK_NONE;
    word_sel = '0;
    pin_sel  = '0;
    addr_i   = int'(reg_addr);
    node_i   = addr_i / WIN_SZ;
    off_i    = addr_i % WIN_SZ;
    if (reg_addr[1:0] == 2'b00) begin
      if (node_i >= 1 && node_i <= NODES) begin
        if (off_i < 4 * TW) begin
          kind     = RK_TYPE;
          word_sel = WSEL_W'((node_i - 1) * TW + off_i / 4);
        end else if (off_i >= VEC_BASE && off_i < VEC_BASE + 4 * PPN) begin
          kind    = RK_VEC;
          pin_sel = IDX_W'((node_i - 1) * PPN + (off_i - VEC_BASE) / 4);
        end
      end else if (addr_i >= CLR_BASE && addr_i < CLR_BASE + 4 * CLR_WORDS) begin
        kind     = RK_CLR;
        word_sel = WSEL_W'((addr_i - CLR_BASE) / 4);
      end
    end
  end

  // read mux
  always_comb begin
    case (kind)
      RK_TYPE: rd_next = trig_q[{word_sel, 5'b0} +: 32];
      RK_VEC:  rd_next = msg_word(dev_id(node_i, DEV_BASE), evt_q[pin_sel]);
      default: rd_next = '0;
    endcase
  end

  // write-one-to-clear strobes, same cycle as the request
  always_comb begin
    clr_hit = '0;
    if (reg_req && reg_wr && kind == RK_CLR)
      clr_hit[{word_sel, 5'b0} +: 32] = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= '0;
      evt_q      <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_req && !reg_wr;
      if (reg_req && !reg_wr)
        reg_rdata <= rd_next;
      if (reg_req && reg_wr) begin
        case (kind)
          RK_TYPE: trig_q[{word_sel, 5'b0} +: 32] <= reg_wdata;
          RK_VEC:  evt_q[pin_sel] <= reg_wdata[DEV_W +: EVT_W];
          default: ;
        endcase
      end
    end
  end

  assign trig_lvl = trig_q;
  assign evt_ids  = evt_q;
endmodule

// File: rtl/w2m_rr_arb.sv
module w2m_rr_arb #(
  parameter int N = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         cand,
  input  logic                 take,
  output logic                 gnt_vld,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] last_q;

  // nearest candidate after 'last', wrapping; N is a power of two
  function automatic logic [IDX_W:0] rr_pick(input logic [N-1:0] c,
                                             input logic [IDX_W-1:0] last);
    logic [IDX_W:0]   res;
    logic [IDX_W-1:0] j;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      j = last + IDX_W'(k);
      if (c[j]) res = {1'b1, j};
    end
    return res;
  endfunction

  logic [IDX_W:0] pick;
  assign pick    = rr_pick(cand, last_q);
  assign gnt_vld = pick[IDX_W];
  assign gnt_idx = pick[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_q <= IDX_W'(N - 1);
    else if (take && gnt_vld)
      last_q <= gnt_idx;
  end
endmodule

// File: rtl/wire2msg_gen.sv
module wire2msg_gen
  import w2m_pkg::*;
#(
  parameter int          NODES    = 2,
  parameter int          PPN      = 128,
  parameter int          ADDR_W   = 16,
  parameter int          DEV_BASE = 256,
  parameter logic [31:0] DOORBELL = 32'h0800_0040
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NODES*PPN-1:0] irq_in,
  input  logic                 reg_req,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_rvalid,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int TOTAL = NODES * PPN;
  localparam int IDX_W = $clog2(TOTAL);

  logic [TOTAL-1:0]            pin_s;
  logic [TOTAL-1:0]            pin_d;
  logic [TOTAL-1:0]            trig_lvl;
  logic [TOTAL-1:0][EVT_W-1:0] evt_ids;
  logic [TOTAL-1:0]            clr_hit;
  logic [TOTAL-1:0]            fire;
  logic [TOTAL-1:0]            pend_q;
  logic [TOTAL-1:0]            sent_q;
  logic [TOTAL-1:0]            cand;
  logic [TOTAL-1:0]            gnt_oh;
  logic                        gnt_vld;
  logic [IDX_W-1:0]            gnt_idx;
  logic                        load_msg;

  w2m_sync #(.WIDTH(TOTAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (pin_s)
  );

  w2m_regs #(
    .NODES    (NODES),
    .PPN      (PPN),
    .ADDR_W   (ADDR_W),
    .DEV_BASE (DEV_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .trig_lvl   (trig_lvl),
    .evt_ids    (evt_ids),
    .clr_hit    (clr_hit)
  );

  w2m_rr_arb #(.N(TOTAL)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .take    (load_msg),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  // trigger detection on the synchronized lines
  assign fire     = (trig_lvl & pin_s) | (~trig_lvl & pin_s & ~pin_d);
  assign cand     = pend_q & ~sent_q;
  assign load_msg = gnt_vld && !msg_valid;

  always_comb begin
    gnt_oh          = '0;
    gnt_oh[gnt_idx] = load_msg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d  <= '0;
      pend_q <= '0;
      sent_q <= '0;
    end else begin
      pin_d  <= pin_s;
      pend_q <= (pend_q & ~clr_hit) | fire;
      sent_q <= (sent_q | gnt_oh) & ~clr_hit;
    end
  end

  // single-entry output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load_msg) begin
      msg_valid <= 1'b1;
      msg_addr  <= DOORBELL;
      msg_data  <= msg_word(dev_id(node_of(int'(gnt_idx), PPN), DEV_BASE),
                            evt_ids[gnt_idx]);
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wire2msg_chk.sv
module wire2msg_chk #(
  parameter int          TOTAL    = 256,
  parameter logic [31:0] DOORBELL = 32'h0800_0040
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     msg_valid,
  input logic                     msg_ready,
  input logic [31:0]              msg_addr,
  input logic [31:0]              msg_data,
  input logic                     reg_req,
  input logic                     reg_wr,
  input logic                     reg_rvalid,
  input logic [TOTAL-1:0]         cand,
  input logic [TOTAL-1:0]         pend_q,
  input logic [TOTAL-1:0]         sent_q,
  input logic [TOTAL-1:0]         fire,
  input logic [TOTAL-1:0]         clr_hit,
  input logic                     gnt_vld,
  input logic [$clog2(TOTAL)-1:0] gnt_idx
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_addr));

  p_doorbell_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr == DOORBELL);

  p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_wr |=> reg_rvalid);

  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && !reg_wr) |=> !reg_rvalid);

  p_grant_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> cand[gnt_idx]);

  p_grant_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> gnt_vld);

  p_sent_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q & ~pend_q) == '0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_hit) |=> (pend_q & $past(clr_hit)) == ($past(fire) & $past(clr_hit)));
endmodule

bind wire2msg_gen wire2msg_chk #(
  .TOTAL    (NODES * PPN),
  .DOORBELL (DOORBELL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .reg_req    (reg_req),
  .reg_wr     (reg_wr),
  .reg_rvalid (reg_rvalid),
  .cand       (cand),
  .pend_q     (pend_q),
  .sent_q     (sent_q),
  .fire       (fire),
  .clr_hit    (clr_hit),
  .gnt_vld    (gnt_vld),
  .gnt_idx    (gnt_idx)
);

// File: tb/wire2msg_gen_test.sv
`timescale 1ns/1ps
module wire2msg_gen_test;
  localparam int TOTAL = 256;
  localparam int PPN   = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [TOTAL-1:0] irq = '0;
  logic        reg_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int failures = 0;
  int last_pin = TOTAL - 1;

  always #4 clk = ~clk;

  wire2msg_gen uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // ---- reference functions from the requirements ----
  function automatic logic [9:0] ev_of(input int c);
    return 10'((c * 7 + 3) % 1024);
  endfunction
  function automatic logic [15:0] a_type(input int c);
    return 16'((c / PPN + 1) * 4096 + 4 * ((c % PPN) / 32));
  endfunction
  function automatic logic [15:0] a_vec(input int c);
    return 16'((c / PPN + 1) * 4096 + 512 + 4 * (c % PPN));
  endfunction
  function automatic logic [15:0] a_clr(input int c);
    return 16'(40960 + 4 * (c / 32));
  endfunction
  function automatic logic [31:0] exp_msg(input int c);
    return {10'b0, ev_of(c), 12'(256 + c / PPN + 1)};
  endfunction
  function automatic int pin_from(input logic [31:0] d);
    for (int c = 0; c < TOTAL; c++)
      if (ev_of(c) == d[21:12]) return c;
    return -1;
  endfunction
  function automatic int rr_next(input logic [TOTAL-1:0] s, input int last);
    for (int k = 1; k <= TOTAL; k++)
      if (s[(last + k) % TOTAL]) return (last + k) % TOTAL;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    chk(reg_rvalid == 1'b1, "R10 rvalid one cycle after read", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic clear_pin(input int c);
    reg_write(a_clr(c), 32'd1 << (c % 32));
  endtask

  task automatic take_msg();
    @(negedge clk);
    msg_ready = 1'b1;
    last_pin = pin_from(msg_data);
    @(posedge clk); #1;
    msg_ready = 1'b0;
  endtask

  task automatic expect_msg(input int c, input string req);
    bit got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
    chk(got, req, 32'(got), 32'd1);
    if (got) begin
      chk(msg_data == exp_msg(c), req, msg_data, exp_msg(c));
      chk(msg_addr == 32'h0800_0040, "R8 doorbell", msg_addr, 32'h0800_0040);
      take_msg();
    end
  endtask

  task automatic expect_none(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, req, 32'(seen), 32'd0);
    if (seen) take_msg();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(msg_valid == 1'b0, "R11 msg_valid after reset", 32'(msg_valid), 0);
    chk(reg_rvalid == 1'b0, "R11 rvalid after reset", 32'(reg_rvalid), 0);
    // R3 reset trigger, R2 reset vector
    reg_read(a_type(200), rd);
    chk(rd == 0, "R3 trigger reset", rd, 0);
    reg_read(a_vec(0), rd);
    chk(rd == 32'h0000_0101, "R2 vector reset", rd, 32'h101);

    // R1 R2 program every pin; device bits and high bits written as garbage
    for (int c = 0; c < TOTAL; c++)
      reg_write(a_vec(c), 32'hFFC0_0ABC | (32'(ev_of(c)) << 12));
    for (int c = 0; c < TOTAL; c += 37) begin
      reg_read(a_vec(c), rd);
      chk(rd == exp_msg(c), "R1 R2 vector readback", rd, exp_msg(c));
    end

    // R12 latency, R8 hold, R4 edge behaviour
    @(negedge clk);
    irq[10] = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(msg_valid == 1'b0, "R12 not before 4th edge", 32'(msg_valid), 0);
    @(posedge clk);
    #1 chk(msg_valid == 1'b1, "R12 valid at 4th edge", 32'(msg_valid), 1);
    held = msg_data;
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_data == held, "R8 held while not ready", msg_data, held);
    chk(held == exp_msg(10), "R8 data format", held, exp_msg(10));
    take_msg();
    expect_none(10, "R6 no repeat while pending");
    clear_pin(10);
    expect_none(10, "R4 held-high edge pin silent after clear");
    @(negedge clk); irq[10] = 1'b0;
    repeat (4) @(negedge clk);
    irq[10] = 1'b1;
    expect_msg(10, "R4 new rising edge");
    clear_pin(10);
    @(negedge clk); irq[10] = 1'b0;

    // R7 zero bits have no effect, R6 edges ignored while pending
    @(negedge clk); irq[40] = 1'b1;
    expect_msg(40, "R4 pin 40 edge");
    reg_write(a_clr(41), 32'd1 << 9);
    @(negedge clk); irq[40] = 1'b0;
    repeat (4) @(negedge clk); irq[40] = 1'b1;
    expect_none(10, "R7 zero clear bit ignored");
    reg_read(a_clr(40), rd);
    chk(rd == 0, "R7 clear word reads zero", rd, 0);
    clear_pin(40);
    @(negedge clk); irq[40] = 1'b0;
    repeat (4) @(negedge clk); irq[40] = 1'b1;
    expect_msg(40, "R7 pin fires after real clear");
    clear_pin(40);
    @(negedge clk); irq[40] = 1'b0;

    // R3 R5 level mode on chip pin 163 (node 2, word 1, bit 3)
    reg_write(16'h2004, 32'h0000_0008);
    reg_read(16'h2004, rd);
    chk(rd == 32'h8, "R3 trigger readback", rd, 32'h8);
    @(negedge clk); irq[163] = 1'b1;
    expect_msg(163, "R5 level fires");
    expect_none(10, "R6 level no repeat before clear");
    clear_pin(163);
    expect_msg(163, "R5 level refires after clear");
    @(negedge clk); irq[163] = 1'b0;
    repeat (4) @(negedge clk);
    clear_pin(163);
    expect_none(10, "R5 level low after clear");
    reg_write(16'h2004, 32'h0);

    // R10 unmapped accesses
    reg_write(16'h0000, 32'hFFFF_FFFF);
    reg_write(16'h1010, 32'hFFFF_FFFF);
    reg_write(16'h3000, 32'hFFFF_FFFF);
    reg_write(16'h0204, 32'hFFFF_FFFF);
    reg_read(16'h0000, rd); chk(rd == 0, "R10 window 0 reads zero", rd, 0);
    reg_read(16'h1010, rd); chk(rd == 0, "R10 gap reads zero", rd, 0);
    reg_read(16'h3000, rd); chk(rd == 0, "R10 missing node reads zero", rd, 0);
    reg_read(16'hA020, rd); chk(rd == 0, "R10 past clear bank reads zero", rd, 0);
    for (int w = 0; w < 4; w++) begin
      reg_read(16'(16'h1000 + 4 * w), rd);
      chk(rd == 0, "R10 trigger words untouched", rd, 0);
    end
    reg_read(a_vec(1), rd);
    chk(rd == exp_msg(1), "R10 vector untouched", rd, exp_msg(1));
    @(negedge clk); irq[1] = 1'b1;
    expect_msg(1, "R10 pin 1 still edge mode");
    clear_pin(1);
    @(negedge clk); irq[1] = 1'b0;

    // R9 random batches in rotating order
    for (int r = 0; r < 30; r++) begin
      logic [TOTAL-1:0] set;
      logic [TOTAL-1:0] left;
      int k;
      int n;
      int guard;
      set = '0;
      k = 1 + int'($urandom % 6);
      n = 0;
      while (n < k) begin
        int p;
        p = int'($urandom % TOTAL);
        if (!set[p]) begin set[p] = 1'b1; n++; end
      end
      if (r == 0) begin set = '0; set[0] = 1; set[255] = 1; set[128] = 1; k = 3; end
      @(negedge clk);
      msg_ready = 1'b0;
      irq = set;
      repeat (8) @(negedge clk);
      left = set;
      n = 0;
      guard = 0;
      while (n < k && guard < 300) begin
        @(negedge clk);
        guard++;
        msg_ready = 1'($urandom % 2);
        if (msg_valid && msg_ready) begin
          int e;
          int got;
          e = rr_next(left, last_pin);
          got = pin_from(msg_data);
          chk(got == e, "R9 rotating order", 32'(got), 32'(e));
          chk(msg_data == exp_msg(e), "R8 batch data", msg_data, exp_msg(e));
          if (got >= 0) left[got] = 1'b0;
          last_pin = got;
          n++;
        end
      end
      @(negedge clk) msg_ready = 1'b0;
      chk(n == k, "R9 batch complete", 32'(n), 32'(k));
      expect_none(5, "R6 batch no extras");
      for (int c = 0; c < TOTAL; c++)
        if (set[c]) clear_pin(c);
      @(negedge clk); irq = '0;
      repeat (4) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule